// File: doc/BRIEF.md
# Pipeline Overflow Exception Controller

This block is the exception controller for a five-stage 16-bit pipeline. It compares the two operands of an add in the execute stage. When their unsigned sum does not fit in 16 bits, it raises a precise trap in that same cycle. Both pipeline registers that hold younger instructions are flushed. The faulting instruction's own register write is cancelled. The program counter is steered to a fixed handler address. Instructions older than the faulting one drain and retire normally.

The controller keeps two exception address registers. One holds the faulting address. The other holds the address after it, which is where a handler resumes the program. Two cycles after the trap, the faulting instruction reaches the writeback slot. Because its own write was cancelled, that slot is free, and the controller uses it to write the faulting address into reserved register 15. A decode-stage read port returns either exception register for a move-from-coprocessor instruction. A register-jump request redirects the program counter to a supplied address, which is how a handler returns.

Top module: `ovf_exc_ctrl`

## Requirements
- R1: A trap is raised when ex_valid_i and ex_add_i are high and ex_opa_i + ex_opb_i, taken as unsigned values, is 65536 or more. For example, 32 + 65527 traps, 0x8000 + 0x7FFF does not trap, and 0x8000 + 0x8000 traps.
- R2: In the trap cycle, flush_ifid_o and flush_idex_o are both high, in the same cycle as the overflowing operands.
- R3: In the trap cycle, ex_kill_o is high so that the faulting instruction's register write is cancelled.
- R4: In the trap cycle, the writeback from the MEM/WB register passes through unchanged: rf_we_o, rf_addr_o and rf_data_o equal wb_we_i, wb_addr_i and wb_data_i.
- R5: From the cycle after a trap, cop_data_o returns the faulting ex_pc_i when cop_sel_i is 0, and that address plus 1 (mod 65536) when cop_sel_i is 1. After reset both registers read 0.
- R6: Two cycles after a trap, the register write port carries rf_we_o=1, rf_addr_o=15 and rf_data_o equal to the faulting address, whatever wb_* carries in that cycle.
- R7: In the trap cycle, pc_redir_o is high and pc_target_o equals HANDLER_ADDR (default 0xC000).
- R8: An overflow in either of the two cycles after a trap is ignored. It produces no flush and no redirect, and it leaves the exception registers unchanged. An overflow in the third cycle after a trap is taken as a new trap.
- R9: Each flush output and the trap redirect is high for exactly one cycle per trap, even when the overflow condition stays high.
- R10: When jr_i is high and there is no trap, pc_redir_o is high, pc_target_o equals jr_addr_i, and neither flush output is raised.
- R11: When jr_i and a trap fall in the same cycle, the trap wins: pc_target_o is HANDLER_ADDR and both flushes are raised.
- R12: An overflowing operand pair produces no trap when ex_add_i is low or when ex_valid_i is low.
- R13: After reset, with all inputs low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ex_valid_i | input | 1 | Execute stage holds a real instruction |
| ex_add_i | input | 1 | Execute stage instruction is an add |
| ex_opa_i | input | 16 | Add operand A |
| ex_opb_i | input | 16 | Add operand B |
| ex_pc_i | input | 16 | Address of the execute-stage instruction |
| jr_i | input | 1 | Register-jump request from decode |
| jr_addr_i | input | 16 | Register-jump target |
| wb_we_i | input | 1 | MEM/WB write enable |
| wb_addr_i | input | 4 | MEM/WB destination register |
| wb_data_i | input | 16 | MEM/WB write data |
| cop_sel_i | input | 1 | Exception register select: 0 faulting address, 1 return address |
| flush_ifid_o | output | 1 | Flush the IF/ID register |
| flush_idex_o | output | 1 | Flush the ID/EX register |
| ex_kill_o | output | 1 | Cancel the execute-stage instruction's register write |
| pc_redir_o | output | 1 | Load pc_target_o into the PC |
| pc_target_o | output | 16 | Redirect address |
| rf_we_o | output | 1 | Register file write enable |
| rf_addr_o | output | 4 | Register file write address |
| rf_data_o | output | 16 | Register file write data |
| cop_data_o | output | 16 | Exception register read data |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a trap and a normal MEM/WB writeback. The bench drives an overflowing add while wb_we_i carries an older instruction's write. It then checks that the flushes and the redirect appear while the register write port shows that older write unchanged. Two cycles later, it drives a live wb_* write and checks that the reserved-register save takes the port instead.

The second pair is a trap and a register jump. The bench raises jr_i together with an overflow and checks that the handler address, not the jump target, is presented.

// File: rtl/ovc_pkg.sv
package ovc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_DRAIN = 2'd1,
    SEQ_SAVE  = 2'd2
  } seq_e;
endpackage

// File: rtl/ovc_detect.sv
module ovc_detect #(
  parameter int DATA_W = 16
) (
  input  logic              valid_i,
  input  logic              add_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic              hit_o
);
  logic carry;
  // a + b wraps exactly when a exceeds (2^W - 1 - b)
  assign carry = opa_i > ~opb_i;
  assign hit_o = valid_i & add_i & carry & ~busy_i;
endmodule

// File: rtl/ovc_seq.sv
module ovc_seq
  import ovc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic busy_o,
  output logic save_o
);
  seq_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE:  if (hit_i) st_d = SEQ_DRAIN;
      SEQ_DRAIN: st_d = SEQ_SAVE;
      SEQ_SAVE:  st_d = SEQ_IDLE;
      default:   st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEQ_IDLE;
    else         st_q <= st_d;
  end

  assign busy_o = st_q != SEQ_IDLE;
  assign save_o = st_q == SEQ_SAVE;
endmodule

// File: rtl/ovc_epc.sv
module ovc_epc #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic              sel_i,
  output logic [DATA_W-1:0] epc_o,
  output logic [DATA_W-1:0] rd_o
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};
  logic [DATA_W-1:0] epc_q, ret_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_q <= '0;
      ret_q <= '0;
    end else if (hit_i) begin
      epc_q <= pc_i;
      ret_q <= pc_i + ONE;
    end
  end

  assign epc_o = epc_q;
  assign rd_o  = sel_i ? ret_q : epc_q;
endmodule

// File: rtl/ovf_exc_ctrl.sv
module ovf_exc_ctrl #(
  parameter int                DATA_W       = 16,
  parameter int                REG_AW       = 4,
  parameter logic [DATA_W-1:0] HANDLER_ADDR = 16'hC000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ex_valid_i,
  input  logic              ex_add_i,
  input  logic [DATA_W-1:0] ex_opa_i,
  input  logic [DATA_W-1:0] ex_opb_i,
  input  logic [DATA_W-1:0] ex_pc_i,
  input  logic              jr_i,
  input  logic [DATA_W-1:0] jr_addr_i,
  input  logic              wb_we_i,
  input  logic [REG_AW-1:0] wb_addr_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic              cop_sel_i,
  output logic              flush_ifid_o,
  output logic              flush_idex_o,
  output logic              ex_kill_o,
  output logic              pc_redir_o,
  output logic [DATA_W-1:0] pc_target_o,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_addr_o,
  output logic [DATA_W-1:0] rf_data_o,
  output logic [DATA_W-1:0] cop_data_o
);
  localparam logic [REG_AW-1:0] RSV_REG = {REG_AW{1'b1}};

  logic hit, busy, save;
  logic [DATA_W-1:0] epc;

  ovc_detect #(.DATA_W(DATA_W)) u_det (
    .valid_i (ex_valid_i),
    .add_i   (ex_add_i),
    .busy_i  (busy),
    .opa_i   (ex_opa_i),
    .opb_i   (ex_opb_i),
    .hit_o   (hit)
  );

  ovc_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .busy_o (busy),
    .save_o (save)
  );

  ovc_epc #(.DATA_W(DATA_W)) u_epc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .pc_i   (ex_pc_i),
    .sel_i  (cop_sel_i),
    .epc_o  (epc),
    .rd_o   (cop_data_o)
  );

  assign flush_ifid_o = hit;
  assign flush_idex_o = hit;
  assign ex_kill_o    = hit;
  assign pc_redir_o   = hit | jr_i;
  assign pc_target_o  = hit ? HANDLER_ADDR : jr_addr_i;

  // the faulting instruction's cancelled writeback slot carries the EPC save
  always_comb begin
    if (save) begin
      rf_we_o   = 1'b1;
      rf_addr_o = RSV_REG;
      rf_data_o = epc;
    end else begin
      rf_we_o   = wb_we_i;
      rf_addr_o = wb_addr_i;
      rf_data_o = wb_data_i;
    end
  end
endmodule

// File: rtl/ovf_exc_ctrl_chk.sv
module ovf_exc_ctrl_chk #(
  parameter int                DATA_W       = 16,
  parameter int                REG_AW       = 4,
  parameter logic [DATA_W-1:0] HANDLER_ADDR = 16'hC000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ex_valid_i,
  input logic              ex_add_i,
  input logic [DATA_W-1:0] ex_pc_i,
  input logic              jr_i,
  input logic [DATA_W-1:0] jr_addr_i,
  input logic              wb_we_i,
  input logic [REG_AW-1:0] wb_addr_i,
  input logic [DATA_W-1:0] wb_data_i,
  input logic              cop_sel_i,
  input logic              flush_ifid_o,
  input logic              flush_idex_o,
  input logic              ex_kill_o,
  input logic              pc_redir_o,
  input logic [DATA_W-1:0] pc_target_o,
  input logic              rf_we_o,
  input logic [REG_AW-1:0] rf_addr_o,
  input logic [DATA_W-1:0] rf_data_o,
  input logic [DATA_W-1:0] cop_data_o
);
  // R2
  flush_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_ifid_o |-> flush_idex_o);
  // R3
  kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_ifid_o |-> ex_kill_o);
  // R7
  redir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_ifid_o |-> (pc_redir_o && pc_target_o == HANDLER_ADDR));
  // R9
  pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_ifid_o |=> !flush_ifid_o);
  // R8
  window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_ifid_o |=> ##1 !flush_idex_o);
  // R6
  save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_ifid_o |=> ##1 (rf_we_o && rf_addr_o == {REG_AW{1'b1}}
                          && rf_data_o == $past(ex_pc_i, 2)));
  // R5
  epc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_ifid_o ##1 !cop_sel_i) |-> cop_data_o == $past(ex_pc_i));
  // R4
  wb_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_ifid_o |-> (rf_we_o == wb_we_i && rf_addr_o == wb_addr_i && rf_data_o == wb_data_i));
  // R12
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ex_valid_i && ex_add_i) |-> !flush_ifid_o);
  // R10
  jr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jr_i && !flush_ifid_o) |-> (pc_redir_o && pc_target_o == jr_addr_i && !flush_idex_o));
endmodule

bind ovf_exc_ctrl ovf_exc_ctrl_chk #(
  .DATA_W(DATA_W), .REG_AW(REG_AW), .HANDLER_ADDR(HANDLER_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ex_valid_i(ex_valid_i), .ex_add_i(ex_add_i),
  .ex_pc_i(ex_pc_i), .jr_i(jr_i), .jr_addr_i(jr_addr_i), .wb_we_i(wb_we_i),
  .wb_addr_i(wb_addr_i), .wb_data_i(wb_data_i), .cop_sel_i(cop_sel_i),
  .flush_ifid_o(flush_ifid_o), .flush_idex_o(flush_idex_o), .ex_kill_o(ex_kill_o),
  .pc_redir_o(pc_redir_o), .pc_target_o(pc_target_o), .rf_we_o(rf_we_o),
  .rf_addr_o(rf_addr_o), .rf_data_o(rf_data_o), .cop_data_o(cop_data_o)
);

// File: tb/sim_ovf_exc_ctrl.sv
module sim_ovf_exc_ctrl;
  localparam logic [15:0] HANDLER = 16'hC000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ex_valid, ex_add, jr, wb_we, cop_sel;
  logic [15:0] opa, opb, ex_pc, jr_addr, wb_data;
  logic [3:0] wb_addr;
  logic flush_ifid, flush_idex, kill, redir, rf_we;
  logic [15:0] target, rf_data, cop_data;
  logic [3:0] rf_addr;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  ovf_exc_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .ex_valid_i(ex_valid), .ex_add_i(ex_add),
    .ex_opa_i(opa), .ex_opb_i(opb), .ex_pc_i(ex_pc), .jr_i(jr), .jr_addr_i(jr_addr),
    .wb_we_i(wb_we), .wb_addr_i(wb_addr), .wb_data_i(wb_data), .cop_sel_i(cop_sel),
    .flush_ifid_o(flush_ifid), .flush_idex_o(flush_idex), .ex_kill_o(kill),
    .pc_redir_o(redir), .pc_target_o(target), .rf_we_o(rf_we), .rf_addr_o(rf_addr),
    .rf_data_o(rf_data), .cop_data_o(cop_data)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    ex_valid = 0; ex_add = 0; opa = 0; opb = 0; ex_pc = 0;
    jr = 0; jr_addr = 0; wb_we = 0; wb_addr = 0; wb_data = 0; cop_sel = 0;
  endtask

  // next negedge, then settle
  task automatic step();
    @(negedge clk);
  endtask

  task automatic drive_add(logic [15:0] a, logic [15:0] b, logic [15:0] pc);
    ex_valid = 1; ex_add = 1; opa = a; opb = b; ex_pc = pc;
  endtask

  task automatic drain();
    idle_in();
    repeat (3) step();
  endtask

  task automatic t_reset();
    idle_in();
    #2;
    chk("R13 flush_ifid", flush_ifid, 0);
    chk("R13 redir", redir, 0);
    chk("R13 rf_we", rf_we, 0);
    chk("R13 cop epc", cop_data, 0);
    cop_sel = 1; #1;
    chk("R5 reset ret reg", cop_data, 0);
    cop_sel = 0;
  endtask

  task automatic t_basic();
    step();
    drive_add(16'd32, 16'd65527, 16'd103);
    wb_we = 1; wb_addr = 4'd3; wb_data = 16'h1234;
    #2;
    chk("R1 32+65527 traps", flush_ifid, 1);
    chk("R2 flush_idex", flush_idex, 1);
    chk("R3 kill", kill, 1);
    chk("R7 redir", redir, 1);
    chk("R7 target", target, HANDLER);
    chk("R4 wb pass we", rf_we, 1);
    chk("R4 wb pass addr", rf_addr, 3);
    chk("R4 wb pass data", rf_data, 16'h1234);
    step();
    idle_in(); wb_we = 1; wb_addr = 4'd5; wb_data = 16'h0055;
    #2;
    chk("R9 flush one cycle", flush_ifid, 0);
    chk("R9 redir one cycle", redir, 0);
    chk("R5 epc", cop_data, 103);
    cop_sel = 1; #1;
    chk("R5 return addr", cop_data, 104);
    chk("R4 older write passes", rf_addr, 5);
    step();
    idle_in(); wb_we = 1; wb_addr = 4'd7; wb_data = 16'h0077;
    #2;
    chk("R6 save we", rf_we, 1);
    chk("R6 save addr R15", rf_addr, 15);
    chk("R6 save data", rf_data, 103);
    step();
    idle_in(); #2;
    chk("R6 save done", rf_we, 0);
    drain();
  endtask

  task automatic t_boundary();
    step();
    drive_add(16'h8000, 16'h7FFF, 16'd10); #2;
    chk("R1 0x8000+0x7FFF no trap", flush_ifid, 0);
    step();
    drive_add(16'h8000, 16'h8000, 16'd11); #2;
    chk("R1 0x8000+0x8000 traps", flush_ifid, 1);
    drain();
  endtask

  task automatic t_gate();
    step();
    drive_add(16'hFFFF, 16'hFFFF, 16'd20); ex_add = 0; #2;
    chk("R12 non-add no trap", flush_ifid, 0);
    step();
    drive_add(16'hFFFF, 16'hFFFF, 16'd21); ex_valid = 0; #2;
    chk("R12 invalid no trap", flush_idex, 0);
    chk("R12 invalid no redir", redir, 0);
    drain();
  endtask

  task automatic t_held();
    step();
    drive_add(16'hFFF0, 16'h0100, 16'd200); #2;
    chk("R8 first trap", flush_ifid, 1);
    step();
    drive_add(16'hFFF0, 16'h0100, 16'd201); #2;
    chk("R9 held ovf no flush", flush_ifid, 0);
    chk("R8 no redir +1", redir, 0);
    step();
    drive_add(16'hFFF0, 16'h0100, 16'd202); #2;
    chk("R8 no flush +2", flush_idex, 0);
    chk("R8 epc kept", cop_data, 200);
    chk("R6 saved first epc", rf_data, 200);
    step();
    drive_add(16'hFFF0, 16'h0100, 16'd203); #2;
    chk("R8 new trap +3", flush_ifid, 1);
    step();
    idle_in(); #2;
    chk("R8 epc updated", cop_data, 203);
    drain();
  endtask

  task automatic t_jr();
    step();
    jr = 1; jr_addr = 16'h0104; #2;
    chk("R10 jr redir", redir, 1);
    chk("R10 jr target", target, 16'h0104);
    chk("R10 jr no flush", flush_ifid, 0);
    step();
    jr = 1; jr_addr = 16'h0200;
    drive_add(16'd1, 16'hFFFF, 16'd300); #2;
    chk("R11 trap wins target", target, HANDLER);
    chk("R11 flush with jr", flush_idex, 1);
    drain();
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_in();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_basic();
    t_boundary();
    t_gate();
    t_held();
    t_jr();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule